// File: doc/BRIEF.md
# 64-bit Variable Shift Unit

This unit shifts a 64-bit operand left or right and registers the shifted value. It can make a logical left shift, a logical right shift or an arithmetic right shift. Bits pushed past either end of the word are dropped, and nothing wraps around to the other end. The operation select sets the direction. The sign of the count never sets it.

The shift distance comes from one of two sources. The first is a full 64-bit count operand, which is compared as an unsigned value. The second is a 6-bit immediate. Any register count above 63 saturates the result instead of wrapping. An execution pipeline issues one operation per cycle with a valid strobe, and it takes the result one cycle later.

Top module: `vshift64`

## Requirements
- R1: With `shift_right`=0 the result is the data moved toward bit 63 by the count, and the vacated low bits become 0.
- R2: With `shift_right`=1 and `arith`=0 the data moves toward bit 0, and the vacated high bits become 0.
- R3: With `shift_right`=1 and `arith`=1 the vacated high bits copy bit 63 of the data. Odd negative values round toward minus infinity, so all ones shifted by 1 stays all ones.
- R4: With `use_imm`=1 the 6-bit `imm` (0 to 63) is the count, and the `count` port has no effect, even when it is above 63.
- R5: With `use_imm`=0, a `count` that has any bit set in positions 63:6 gives an all-zero result. The one exception is R6.
- R6: An arithmetic right shift of data with bit 63 set, by a register count above 63, gives all ones.
- R7: A count of zero returns the data unchanged for every operation.
- R8: `arith` has no effect when `shift_right`=0.
- R9: `out_valid` equals `in_valid` of the previous cycle. The result of an operation appears on `result` in the cycle after its `in_valid`.
- R10: While `in_valid` is 0, `result` keeps its last value.
- R11: After reset `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| shift_right | input | 1 | 0 = shift left, 1 = shift right |
| arith | input | 1 | With a right shift, fill with the sign bit |
| data | input | 64 | Operand to shift |
| count | input | 64 | Register shift count, unsigned |
| use_imm | input | 1 | Take the count from `imm` |
| imm | input | 6 | Immediate shift count |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered shift result |

## Verification
Two cases let two functions act in the same cycle. Saturation and sign fill meet when an arithmetic right shift of a negative value gets a register count above 63. Immediate selection and saturation meet when `use_imm` is set while `count` holds a huge value, and the immediate must win. The bench drives both pairings directly and again inside random traffic that picks counts near 63, 64 and the high bits. A behavioural bit-by-bit model judges every cycle's output against the requirement rules.

// File: rtl/vshift64.sv
module vshift64 #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         shift_right,
  input  logic         arith,
  input  logic [W-1:0] data,
  input  logic [W-1:0] count,
  input  logic         use_imm,
  input  logic [$clog2(W)-1:0] imm,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] amt;
  logic          over;
  logic          fill;
  logic [W-1:0]  shl, shr, nxt;

  assign amt  = use_imm ? imm : count[CW-1:0];
  assign over = !use_imm && (|count[W-1:CW]);
  assign fill = shift_right && arith && data[W-1];

  assign shl = data << amt;
  assign shr = arith ? W'($signed(data) >>> amt) : (data >> amt);

  assign nxt = over ? {W{fill}} : (shift_right ? shr : shl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/vshift64_chk.sv
module vshift64_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         shift_right,
  input logic         arith,
  input logic [W-1:0] data,
  input logic [W-1:0] count,
  input logic         use_imm,
  input logic [$clog2(W)-1:0] imm,
  input logic         out_valid,
  input logic [W-1:0] result
);
  localparam int CW = $clog2(W);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R10
  AST_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_imm && (|count[W-1:CW]) && !(shift_right && arith && data[W-1])) |=> (result == '0)); // R5
  AST_SAT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_imm && (|count[W-1:CW]) && shift_right && arith && data[W-1]) |=> (&result)); // R6
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && use_imm && imm == '0) |=> (result == $past(data))); // R7
  AST_SRL_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_right && !arith && use_imm && imm != '0) |=> !result[W-1]); // R2
  AST_SLL_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !shift_right && use_imm && imm != '0) |=> !result[0]); // R1
endmodule

bind vshift64 vshift64_chk #(.W(W)) u_chk (.*);

// File: tb/vshift64_tb.sv
`timescale 1ns/1ps
module vshift64_tb;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, shift_right = 0, arith = 0, use_imm = 0;
  logic [63:0] data = '0, count = '0;
  logic [5:0]  imm = '0;
  logic        out_valid;
  logic [63:0] result;
  int checks = 0, errors = 0;
  logic [63:0] exp_res = '0;
  logic        exp_v = 0;

  always #4 clk = ~clk;

  vshift64 u_dut (.*);

  function automatic logic [63:0] ref_shift(logic r, logic a, logic [63:0] d,
                                            logic [63:0] c);
    logic [63:0] o;
    logic f;
    int k;
    f = r && a && d[63];
    if (c > 64'd63) return {64{f}};
    k = int'(c[6:0]);
    for (int i = 0; i < 64; i++) begin
      if (!r) o[i] = (i >= k) ? d[i-k] : 1'b0;
      else    o[i] = (i + k <= 63) ? d[i+k] : f;
    end
    return o;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic r, logic a, logic [63:0] d, logic [63:0] c,
                      logic ui, logic [5:0] im, string tag);
    in_valid = v; shift_right = r; arith = a; data = d; count = c;
    use_imm = ui; imm = im;
    @(negedge clk);
    if (v) exp_res = ref_shift(r, a, d, ui ? {58'd0, im} : c);
    exp_v = v;
    chk({tag, " R9 valid"}, {63'd0, out_valid}, {63'd0, exp_v});
    chk(tag, result, exp_res);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R11 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R11 reset result", result, 64'd0);
    rst_n = 1;
    @(negedge clk);
    step(1, 0, 0, 64'h8000_0000_0000_0001, 64'd1, 0, 0, "R1 left by 1");
    step(1, 0, 1, 64'hFFFF_0000_1234_5678, 64'd8, 0, 0, "R8 arith ignored left");
    step(1, 1, 0, 64'h8000_0000_0000_00F0, 64'd4, 0, 0, "R2 logical right");
    step(1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, "R3 minus one stays");
    step(1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFD, 64'd1, 0, 0, "R3 -3 to -2");
    step(1, 1, 1, 64'h8000_0000_0000_0000, 64'd63, 0, 0, "R3 full sign fill");
    step(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 0, 0, "R5 left count 64");
    step(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, 0, "R5 huge count");
    step(1, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd100, 0, 0, "R5 positive sra");
    step(1, 1, 1, 64'h8000_0000_0000_0000, 64'd64, 0, 0, "R6 negative sra sat");
    step(1, 1, 1, 64'hC000_0000_0000_0000, 64'h0000_0001_0000_0000, 0, 0, "R6 high count bit");
    step(1, 0, 0, 64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 6'd4, "R4 imm wins");
    step(1, 1, 1, 64'h8000_0000_0000_0000, 64'd200, 1, 6'd63, "R4 imm sra 63");
    step(1, 1, 0, 64'h1234_5678_9ABC_DEF0, 64'd0, 0, 0, "R7 zero srl");
    step(1, 1, 1, 64'hF234_5678_9ABC_DEF0, 64'd5, 1, 6'd0, "R7 zero sra imm");
    step(1, 0, 0, 64'hA5A5_A5A5_A5A5_A5A5, 64'd0, 0, 0, "R7 zero sll");
    step(0, 0, 0, 64'hDEAD_BEEF_DEAD_BEEF, 64'd3, 0, 0, "R10 hold");
    step(0, 1, 1, 64'h0, 64'd0, 1, 6'd9, "R10 hold again");
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] c;
      logic r, a;
      string tag;
      r = 1'($urandom); a = 1'($urandom);
      case ($urandom_range(0, 3))
        0: c = 64'($urandom_range(0, 63));
        1: c = 64'($urandom_range(62, 66));
        2: c = 64'd1 << $urandom_range(6, 63);
        default: c = {$urandom, $urandom};
      endcase
      tag = !r ? "R1 random" : (a ? "R3 random" : "R2 random");
      step(($urandom_range(0, 4) != 0), r, a, {$urandom, $urandom}, c,
           1'($urandom), 6'($urandom), tag);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule